// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block is the host side of an in-system programming link. One start pulse runs a whole session against a target device. The block drives the target's reset and serial clock low, gives a short reset pulse and waits a settling delay. It then sends a four-byte enable frame and checks the byte the target echoes back while the third byte is shifted.

When the echo is wrong, the block pulses reset and tries again. After a set number of attempts it stops and raises an error flag. When the echo is right, it reads one page of 16-bit words from a local source through an index port. A page that holds only erased words (all ones) is skipped. Otherwise each word is loaded as two byte frames, the page is committed with one write frame, and completion is awaited. The block polls the first word's low byte when that byte is not 0xFF, and waits a fixed time when it is.

The serial clock runs at a parameterised number of system cycles per half period. Output data changes while the clock falls and input data is sampled as it rises. At the end of the session the target reset is released.

Top module: `serprog_host`

## Requirements
- R1: After system reset and between sessions, `tgt_rst` is high and `sck`, `mosi`, `done` and `err` are low.
- R2: In the cycle after `start` is seen, `tgt_rst` goes low for RST_CYC cycles, then high for RST_CYC cycles, then low for SETTLE_CYC cycles before the first frame. `sck` stays low throughout.
- R3: A frame is 32 bits, sent most significant bit first. Each bit keeps `mosi` steady for 2*HALF_CYC cycles, with `sck` low for the first HALF_CYC and high for the second. `miso` is sampled on the rising `sck`. There is exactly one idle cycle with `sck` and `mosi` low before and after each frame.
- R4: The enable frame carries bytes 0xAC, 0x53, 0x00, 0x00. The third byte returned on `miso` is compared with 0x53 only after all four bytes have been sent.
- R5: On a wrong echo, `tgt_rst` goes high for RST_CYC cycles and low for SETTLE_CYC cycles, and the enable frame is sent again. After MAX_TRIES wrong echoes in one session, `err` goes high with `tgt_rst` high and no further frames, until the next `start`.
- R6: After a good echo, the block presents word indices 0 to PAGE_WORDS-1 on `wd_idx`, one per cycle. If every word read is 0xFFFF, no page frames are sent and the session finishes at once.
- R7: For each word in ascending index order, two load frames are sent: first 0x40, 0x00, index, low byte, then 0x48, 0x00, index, high byte.
- R8: After the last load, one write frame 0x4C, address high, address low, 0x00 is sent. The 16-bit word address is `page` times PAGE_WORDS.
- R9: If the low byte of word 0 is not 0xFF, read frames 0x20, address high, address low, 0x00 are sent back to back until the fourth returned byte equals that low byte.
- R10: If the low byte of word 0 is 0xFF, the block waits WR_CYC cycles after the write frame instead of polling.
- R11: A session ends with `done` high for one cycle with `tgt_rst` high, then the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| start | input | 1 | One-cycle request to run a session |
| page | input | PAGE_W | Page number to program, captured at start |
| done | output | 1 | One-cycle pulse when the session completes |
| err | output | 1 | High after enabling failed MAX_TRIES times |
| wd_idx | output | log2(PAGE_WORDS) | Index of the requested page word |
| wd_data | input | 16 | Page word at `wd_idx`, valid in the same cycle |
| sck | output | 1 | Serial clock to the target |
| mosi | output | 1 | Serial data to the target |
| miso | input | 1 | Serial data from the target |
| tgt_rst | output | 1 | Target reset pin level |

## Verification
Almost every internal state of this sequencer can be seen on the pins within one cycle. A wrong state or a miscounted timer shows up at once as a wrong `tgt_rst` level or an `sck` edge in the wrong cycle. A wrong frame byte or a misordered word shows up as a wrong `mosi` bit, inside the half-period where that bit is sent. Wrong echo or poll decisions show up at the end of the frame concerned: the next cycle brings a reset pulse, a repeated frame or a `done` pulse that the pin model does not expect.

// File: rtl/serprog_host.sv
module serprog_host #(
  parameter int HALF_CYC   = 4,
  parameter int RST_CYC    = 4,
  parameter int SETTLE_CYC = 1_000_000,
  parameter int WR_CYC     = 225_000,
  parameter int MAX_TRIES  = 4,
  parameter int PAGE_WORDS = 32,
  parameter int PAGE_W     = 7,
  localparam int IDX_W     = $clog2(PAGE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] page,
  output logic              done,
  output logic              err,
  output logic [IDX_W-1:0]  wd_idx,
  input  logic [15:0]       wd_data,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              tgt_rst
);

  localparam int HW = $clog2(HALF_CYC + 1);
  localparam int TW = $clog2(MAX_TRIES + 1);
  localparam logic [7:0] OP_EN  = 8'hAC;
  localparam logic [7:0] SYNC   = 8'h53;
  localparam logic [7:0] OP_LLO = 8'h40;
  localparam logic [7:0] OP_LHI = 8'h48;
  localparam logic [7:0] OP_WPG = 8'h4C;
  localparam logic [7:0] OP_RLO = 8'h20;

  typedef enum logic [3:0] {
    S_IDLE, S_RLOW, S_RPUL, S_SETL, S_ENA, S_SCAN,
    S_LOAD, S_WPG, S_POLL, S_WAIT, S_FIN, S_ERR
  } st_t;

  st_t               st;
  logic [31:0]       cnt;
  logic [TW-1:0]     tries;
  logic [IDX_W-1:0]  idx;
  logic              hb, nonff, issued;
  logic [7:0]        poll_val;
  logic [PAGE_W-1:0] pg;

  logic              fr_act, fr_done, sck_q;
  logic [31:0]       sh, tx;
  logic [15:0]       rx;
  logic [4:0]        bitn;
  logic [HW-1:0]     dcnt;

  logic        fr_state, go, last_idx, word_ff;
  logic [15:0] waddr;

  assign fr_state = (st == S_ENA) || (st == S_LOAD) || (st == S_WPG) || (st == S_POLL);
  assign go       = fr_state && !issued;
  assign last_idx = (idx == IDX_W'(PAGE_WORDS - 1));
  assign word_ff  = (wd_data == 16'hFFFF);
  assign waddr    = 16'({pg, idx});

  always_comb begin
    case (st)
      S_ENA:   tx = {OP_EN, SYNC, 16'h0000};
      S_LOAD:  tx = hb ? {OP_LHI, 8'h00, 8'(idx), wd_data[15:8]}
                       : {OP_LLO, 8'h00, 8'(idx), wd_data[7:0]};
      S_WPG:   tx = {OP_WPG, waddr, 8'h00};
      default: tx = {OP_RLO, waddr, 8'h00};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      tries    <= '0;
      idx      <= '0;
      hb       <= 1'b0;
      nonff    <= 1'b0;
      issued   <= 1'b0;
      poll_val <= '0;
      pg       <= '0;
    end else begin
      if (go)      issued <= 1'b1;
      if (fr_done) issued <= 1'b0;
      case (st)
        S_IDLE, S_ERR:
          if (start) begin
            st    <= S_RLOW;
            cnt   <= '0;
            tries <= '0;
            pg    <= page;
          end
        S_RLOW:
          if (cnt == 32'(RST_CYC - 1)) begin
            st  <= S_RPUL;
            cnt <= '0;
          end else cnt <= cnt + 1;
        S_RPUL:
          if (cnt == 32'(RST_CYC - 1)) begin
            st  <= S_SETL;
            cnt <= '0;
          end else cnt <= cnt + 1;
        S_SETL:
          if (cnt == 32'(SETTLE_CYC - 1)) begin
            st  <= S_ENA;
            cnt <= '0;
          end else cnt <= cnt + 1;
        S_ENA:
          if (fr_done) begin
            if (rx[15:8] == SYNC) begin
              st    <= S_SCAN;
              idx   <= '0;
              nonff <= 1'b0;
            end else if (tries == TW'(MAX_TRIES - 1)) begin
              st <= S_ERR;
            end else begin
              tries <= tries + 1;
              st    <= S_RPUL;
              cnt   <= '0;
            end
          end
        S_SCAN: begin
          if (!word_ff) nonff <= 1'b1;
          if (idx == '0) poll_val <= wd_data[7:0];
          if (last_idx) begin
            idx <= '0;
            hb  <= 1'b0;
            st  <= (nonff || !word_ff) ? S_LOAD : S_FIN;
          end else idx <= idx + 1;
        end
        S_LOAD:
          if (fr_done) begin
            if (!hb) hb <= 1'b1;
            else begin
              hb <= 1'b0;
              if (last_idx) begin
                idx <= '0;
                st  <= S_WPG;
              end else idx <= idx + 1;
            end
          end
        S_WPG:
          if (fr_done) begin
            st  <= (poll_val == 8'hFF) ? S_WAIT : S_POLL;
            cnt <= '0;
          end
        S_POLL:
          if (fr_done && rx[7:0] == poll_val) st <= S_FIN;
        S_WAIT:
          if (cnt == 32'(WR_CYC - 1)) st <= S_FIN;
          else cnt <= cnt + 1;
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fr_act  <= 1'b0;
      fr_done <= 1'b0;
      sck_q   <= 1'b0;
      sh      <= '0;
      rx      <= '0;
      bitn    <= '0;
      dcnt    <= '0;
    end else begin
      fr_done <= 1'b0;
      if (go) begin
        fr_act <= 1'b1;
        sh     <= tx;
        bitn   <= '0;
        dcnt   <= '0;
        sck_q  <= 1'b0;
      end else if (fr_act) begin
        if (dcnt == HW'(HALF_CYC - 1)) begin
          dcnt <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx    <= {rx[14:0], miso};
          end else begin
            sck_q <= 1'b0;
            sh    <= {sh[30:0], 1'b0};
            if (bitn == 5'd31) begin
              fr_act  <= 1'b0;
              fr_done <= 1'b1;
            end else bitn <= bitn + 1;
          end
        end else dcnt <= dcnt + 1;
      end
    end
  end

  assign sck     = sck_q;
  assign mosi    = fr_act & sh[31];
  assign done    = (st == S_FIN);
  assign err     = (st == S_ERR);
  assign wd_idx  = idx;
  assign tgt_rst = (st == S_IDLE) || (st == S_RPUL) || (st == S_FIN) || (st == S_ERR);

endmodule

// File: rtl/serprog_host_chk.sv
module serprog_host_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic done,
  input logic err,
  input logic sck,
  input logic mosi,
  input logic tgt_rst
);

  p_no_clock_in_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_rst |-> !sck);

  p_mosi_steady_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));

  p_done_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_releases_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> tgt_rst && !err);

  p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> tgt_rst && !sck && !mosi);

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);

endmodule

bind serprog_host serprog_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .err(err),
  .sck(sck), .mosi(mosi), .tgt_rst(tgt_rst)
);

// File: tb/serprog_host_test.sv
module serprog_host_test;
  localparam int H    = 2;
  localparam int RST  = 3;
  localparam int SET  = 10;
  localparam int WR   = 20;
  localparam int MAXT = 3;
  localparam int PW   = 4;
  localparam int PGW  = 7;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, miso = 1'b0;
  logic [PGW-1:0] page = '0;
  logic [15:0] mem [PW];
  logic [1:0]  wd_idx;
  logic [15:0] wd_data;
  logic done, err, sck, mosi, tgt_rst;
  int nchk = 0, nfail = 0;
  string tag = "R1";

  always #10 clk = ~clk;
  assign wd_data = mem[wd_idx];

  serprog_host #(.HALF_CYC(H), .RST_CYC(RST), .SETTLE_CYC(SET), .WR_CYC(WR),
                 .MAX_TRIES(MAXT), .PAGE_WORDS(PW), .PAGE_W(PGW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .page(page), .done(done), .err(err),
    .wd_idx(wd_idx), .wd_data(wd_data), .sck(sck), .mosi(mosi), .miso(miso),
    .tgt_rst(tgt_rst));

  task automatic cmp(input string nm, input logic a, input logic e);
    nchk++;
    if (a !== e) begin
      nfail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, nm, a, e, $time);
    end
  endtask

  task automatic step(input logic er, es, em, ed, ee, mi);
    @(negedge clk);
    start = 1'b0;
    miso  = mi;
    cmp("tgt_rst", tgt_rst, er);
    cmp("sck", sck, es);
    cmp("mosi", mosi, em);
    cmp("done", done, ed);
    cmp("err", err, ee);
    @(posedge clk);
  endtask

  task automatic frame(input string ft, input logic [31:0] tx, input logic [31:0] rsp);
    tag = {ft, "/R3"};
    step(0, 0, 0, 0, 0, 0);
    for (int b = 31; b >= 0; b--) begin
      repeat (H) step(0, 0, tx[b], 0, 0, rsp[b]);
      repeat (H) step(0, 1, tx[b], 0, 0, rsp[b]);
    end
    step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic session(input logic [PGW-1:0] pg, input int bad_echo, input int busy);
    logic [15:0] wa;
    logic [7:0]  pv;
    logic        allff;
    wa = 16'(pg) * 16'(PW);
    pv = mem[0][7:0];
    allff = 1'b1;
    for (int w = 0; w < PW; w++) if (mem[w] != 16'hFFFF) allff = 1'b0;
    @(negedge clk);
    start = 1'b1;
    page  = pg;
    @(posedge clk);
    tag = "R2";
    repeat (RST) step(0, 0, 0, 0, 0, 0);
    repeat (RST) step(1, 0, 0, 0, 0, 0);
    repeat (SET) step(0, 0, 0, 0, 0, 0);
    for (int a = 0; a < MAXT; a++) begin
      logic [7:0] echo;
      echo = (a < bad_echo) ? 8'h00 : 8'h53;
      frame("R4", {8'hAC, 8'h53, 16'h0000}, {8'h00, 8'hAC, echo, 8'h00});
      if (echo == 8'h53) break;
      tag = "R5";
      if (a == MAXT - 1) begin
        repeat (6) step(1, 0, 0, 0, 1, 0);
        return;
      end
      repeat (RST) step(1, 0, 0, 0, 0, 0);
      repeat (SET) step(0, 0, 0, 0, 0, 0);
    end
    tag = "R6";
    repeat (PW) step(0, 0, 0, 0, 0, 0);
    if (!allff) begin
      for (int w = 0; w < PW; w++) begin
        frame("R7", {8'h40, 8'h00, 8'(w), mem[w][7:0]}, 32'h0);
        frame("R7", {8'h48, 8'h00, 8'(w), mem[w][15:8]}, 32'h0);
      end
      frame("R8", {8'h4C, wa, 8'h00}, 32'h0);
      if (pv == 8'hFF) begin
        tag = "R10";
        repeat (WR) step(0, 0, 0, 0, 0, 0);
      end else begin
        for (int p = 0; p <= busy; p++)
          frame("R9", {8'h20, wa, 8'h00}, {24'h0, (p < busy) ? ~pv : pv});
      end
    end
    tag = "R11";
    step(1, 0, 0, 1, 0, 0);
    tag = "R1";
    repeat (3) step(1, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    for (int w = 0; w < PW; w++) mem[w] = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    tag = "R1";
    repeat (4) step(1, 0, 0, 0, 0, 0);

    mem[0] = 16'hA53C; mem[1] = 16'h00FF; mem[2] = 16'hFFFF; mem[3] = 16'h8001;
    session(7'd5, 1, 2);

    mem[0] = 16'h12FF; mem[1] = 16'hFFFF; mem[2] = 16'hFFFF; mem[3] = 16'h7E00;
    session(7'h7F, 0, 0);

    for (int w = 0; w < PW; w++) mem[w] = 16'hFFFF;
    session(7'd3, 0, 0);

    mem[0] = 16'h0001; mem[1] = 16'h0203; mem[2] = 16'h0405; mem[3] = 16'h0607;
    session(7'd9, MAXT, 0);

    session(7'd1, 0, 0);

    summary();
    $finish;
  end
endmodule